// File: doc/BRIEF.md
# Frame Timestamp Counter

This block keeps a free-running 32-bit time base for a bus controller. A 16-bit divider sets how many clock cycles pass between two steps of the count. Each time the protocol engine marks the start of a frame, the block copies the count into a capture register, so software can later read when that frame began. When the count rolls over from all ones to zero, the block emits a one-cycle wrap event. The same event also goes to the controller's interrupt unit, gated by a dedicated enable bit.

Software reaches the block through a small word-wide register port. Writes are strobed, and a combinational read mux shows any register selected by the address. The port has four registers:

- control, at address 0: bit 0 enables counting and capture, and bit 1 enables the wrap interrupt.
- divider, at address 1.
- live count, at address 2. It can be read, and a write preloads it.
- captured stamp, at address 3. It is read-only.

The live count and the stamp are also driven on dedicated outputs.

Top module: `frame_stamp_timer`

## Requirements
- R1: After reset, control reads 0, the divider reads 31, the live count and the stamp read 0, and no wrap event or interrupt is driven.
- R2: While enabled with divider value D, the count advances by exactly one once every D+1 clock cycles.
- R3: While control bit 0 is 0, the count and the divider phase hold. Setting the bit again resumes from the held phase without clearing anything.
- R4: A frame-start pulse while enabled copies the count as it was before that clock edge into the stamp, visible from the next cycle.
- R5: A frame-start pulse while control bit 0 is 0 leaves the stamp unchanged.
- R6: The wrap event is high for exactly one cycle. That is the cycle in which the count first shows 0 after holding all ones.
- R7: The wrap interrupt equals the wrap event when control bit 1 is 1, and stays low when that bit is 0.
- R8: A write to address 2 loads the live count at that edge. It takes priority over an advance in the same cycle, and that cycle raises no wrap event.
- R9: A write to address 3 has no effect on the stamp. The read port returns control as {zeros, bit1 irq enable, bit0 enable}, with unused high bits read as 0.
- R10: With divider value 0, the count advances on every clock cycle while enabled.
- R11: If the divider is lowered to a value at or below the phase already reached, the count advances at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 divider, 2 live count, 3 stamp |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| frame_start_i | input | 1 | One-cycle frame-start marker from the protocol engine |
| count_o | output | 32 | Live count |
| stamp_o | output | 32 | Count captured at the last frame start |
| wrap_pulse_o | output | 1 | Unmasked wrap event |
| wrap_irq_o | output | 1 | Wrap event gated by control bit 1 |

## Verification
The bound assertions check the local rules on every cycle:

- The count never moves by more than one step without a preload.
- The count and the stamp hold while counting is disabled.
- A capture takes the count from the cycle before.
- The wrap event lasts one cycle and coincides with a zero count.
- The interrupt never fires without the event and its enable.

Some properties span many cycles or depend on register history, and only the bench's reference model and directed scenarios can show them. These are the exact D+1 spacing, a resumed phase after a pause, a single wrap over a long window, write priority, and the effect of a lowered divider in mid-period.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_DIV   = 2'd1,
        REG_COUNT = 2'd2,
        REG_STAMP = 2'd3
    } tsc_reg_e;

    typedef struct packed {
        logic irq_en;
        logic run_en;
    } tsc_ctrl_t;

    localparam int CTRL_W = $bits(tsc_ctrl_t);

    function automatic tsc_ctrl_t ctrl_from_bits(input logic [CTRL_W-1:0] b);
        tsc_ctrl_t c;
        c.run_en = b[0];
        c.irq_en = b[1];
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_to_bits(input tsc_ctrl_t c);
        return {c.irq_en, c.run_en};
    endfunction

endpackage

// File: rtl/tsc_cfg_regs.sv
module tsc_cfg_regs
    import tsc_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int DIV_RST = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  tsc_reg_e          addr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic [DIV_W-1:0]  div_wdata,
    output tsc_ctrl_t         ctrl_q,
    output logic [DIV_W-1:0]  div_q
);

    localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= DIV_INIT;
        end else if (we) begin
            case (addr)
                REG_CTRL: ctrl_q <= ctrl_from_bits(ctrl_wdata);
                REG_DIV:  div_q  <= div_wdata;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/tsc_prescaler.sv
module tsc_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick_o
);

    logic [DIV_W-1:0] phase_q;
    logic             reached;

    // Compare with >= so a divider lowered mid-period takes effect at once.
    assign reached = (phase_q >= div_val);
    assign tick_o  = run_en && reached;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (run_en) begin
            if (reached) phase_q <= '0;
            else         phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/tsc_counter.sv
module tsc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= '0;
            wrap_o  <= 1'b0;
        end else begin
            wrap_o <= 1'b0;
            if (load) begin
                count_o <= load_val;
            end else if (tick) begin
                count_o <= count_o + 1'b1;
                wrap_o  <= (count_o == CNT_MAX);
            end
        end
    end

endmodule

// File: rtl/tsc_capture.sv
module tsc_capture #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             frame_start,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] stamp_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stamp_o <= '0;
        end else if (run_en && frame_start) begin
            stamp_o <= count;
        end
    end

endmodule

// File: rtl/frame_stamp_timer.sv
module frame_stamp_timer
    import tsc_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int DIV_W   = 16,
    parameter int DIV_RST = 31,
    parameter int BUS_W   = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [BUS_W-1:0] cfg_wdata,
    output logic [BUS_W-1:0] cfg_rdata,
    input  logic             frame_start_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] stamp_o,
    output logic             wrap_pulse_o,
    output logic             wrap_irq_o
);

    tsc_reg_e         reg_sel;
    tsc_ctrl_t        ctrl_q;
    logic [DIV_W-1:0] div_q;
    logic             run_en;
    logic             irq_en;
    logic             tick;
    logic             cnt_load;

    assign reg_sel  = tsc_reg_e'(cfg_addr);
    assign run_en   = ctrl_q.run_en;
    assign irq_en   = ctrl_q.irq_en;
    assign cnt_load = cfg_we && (reg_sel == REG_COUNT);

    tsc_cfg_regs #(
        .DIV_W   (DIV_W),
        .DIV_RST (DIV_RST)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (cfg_we),
        .addr       (reg_sel),
        .ctrl_wdata (cfg_wdata[CTRL_W-1:0]),
        .div_wdata  (cfg_wdata[DIV_W-1:0]),
        .ctrl_q     (ctrl_q),
        .div_q      (div_q)
    );

    tsc_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run_en  (run_en),
        .div_val (div_q),
        .tick_o  (tick)
    );

    tsc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (cnt_load),
        .load_val (cfg_wdata[CNT_W-1:0]),
        .count_o  (count_o),
        .wrap_o   (wrap_pulse_o)
    );

    tsc_capture #(.CNT_W(CNT_W)) u_cap (
        .clk         (clk),
        .rst         (rst),
        .run_en      (run_en),
        .frame_start (frame_start_i),
        .count       (count_o),
        .stamp_o     (stamp_o)
    );

    assign wrap_irq_o = wrap_pulse_o && irq_en;

    always_comb begin
        case (reg_sel)
            REG_CTRL:  cfg_rdata = BUS_W'(ctrl_to_bits(ctrl_q));
            REG_DIV:   cfg_rdata = BUS_W'(div_q);
            REG_COUNT: cfg_rdata = BUS_W'(count_o);
            default:   cfg_rdata = BUS_W'(stamp_o);
        endcase
    end

endmodule

// File: rtl/tsc_chk.sv
module tsc_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             run_en,
    input logic             irq_en,
    input logic             frame_start,
    input logic             cnt_load,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] stamp,
    input logic             wrap,
    input logic             irq
);

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_load |=> (count == $past(count)) || (count == $past(count) + 1'b1));

    // R3
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !cnt_load) |=> $stable(count));

    // R4
    capture_value_chk: assert property (@(posedge clk) disable iff (rst)
        (run_en && frame_start) |=> (stamp == $past(count)));

    // R5
    stamp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(run_en && frame_start) |=> $stable(stamp));

    // R6
    wrap_single_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> !wrap);

    // R6
    wrap_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (count == '0));

    // R7
    irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (wrap && irq_en));

endmodule

bind frame_stamp_timer tsc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .run_en      (run_en),
    .irq_en      (irq_en),
    .frame_start (frame_start_i),
    .cnt_load    (cnt_load),
    .count       (count_o),
    .stamp       (stamp_o),
    .wrap        (wrap_pulse_o),
    .irq         (wrap_irq_o)
);

// File: tb/tb_frame_stamp_timer.sv
`timescale 1ns/1ps
module tb_frame_stamp_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        frame_start_i = 1'b0;
    logic [31:0] count_o;
    logic [31:0] stamp_o;
    logic        wrap_pulse_o;
    logic        wrap_irq_o;

    always #2 clk = ~clk;

    frame_stamp_timer dut (
        .clk           (clk),
        .rst           (rst),
        .cfg_we        (cfg_we),
        .cfg_addr      (cfg_addr),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .frame_start_i (frame_start_i),
        .count_o       (count_o),
        .stamp_o       (stamp_o),
        .wrap_pulse_o  (wrap_pulse_o),
        .wrap_irq_o    (wrap_irq_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // Behavioural reference state
    bit          m_run, m_irq, m_wrap;
    int unsigned m_div, m_wait;
    bit [31:0]   m_cnt, m_stamp;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {30'd0, m_irq, m_run};
            2'd1:    return m_div;
            2'd2:    return m_cnt;
            default: return m_stamp;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_irq = 0; m_div = 31; m_wait = 0;
            m_cnt = 0; m_stamp = 0; m_wrap = 0;
        end else begin
            bit        adv;
            bit [31:0] old_cnt;
            old_cnt = m_cnt;
            adv     = m_run && (m_wait >= m_div);
            m_wrap  = 0;
            if (m_run && frame_start_i) m_stamp = old_cnt;
            if (m_run) m_wait = adv ? 0 : m_wait + 1;
            if (cfg_we && cfg_addr == 2'd2) begin
                m_cnt = cfg_wdata;
            end else if (adv) begin
                m_cnt  = old_cnt + 1;
                m_wrap = (old_cnt == 32'hFFFF_FFFF);
            end
            if (cfg_we && cfg_addr == 2'd0) begin
                m_run = cfg_wdata[0];
                m_irq = cfg_wdata[1];
            end
            if (cfg_we && cfg_addr == 2'd1) m_div = cfg_wdata[15:0];
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check("R2 count", count_o, m_cnt);
            check("R4 stamp", stamp_o, m_stamp);
            check("R6 wrap", {31'd0, wrap_pulse_o}, {31'd0, m_wrap});
            check("R7 irq", {31'd0, wrap_irq_o}, {31'd0, m_wrap & m_irq});
            check("R9 rdata", cfg_rdata, exp_read(cfg_addr));
        end
    end

    task automatic sync();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        sync();
        cfg_we = 0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] c0, s0;
        int hits;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        cmp_on = 1;

        // R1 reset state
        cfg_addr = 2'd1;
        @(negedge clk);
        check("R1 divider", cfg_rdata, 32'd31);
        check("R1 count", count_o, 32'd0);
        check("R1 stamp", stamp_o, 32'd0);
        check("R1 wrap", {31'd0, wrap_pulse_o | wrap_irq_o}, 32'd0);
        sync();
        cfg_addr = 2'd0;
        @(negedge clk);
        check("R1 ctrl", cfg_rdata, 32'd0);
        sync();

        // R2 period D+1 with D=3
        wr(2'd1, 32'd3);
        wr(2'd0, 32'd1);
        repeat (3) sync();
        @(negedge clk); c0 = count_o;
        repeat (8) @(negedge clk);
        check("R2 period", count_o, c0 + 2);
        sync();

        // R3 hold while disabled
        wr(2'd0, 32'd0);
        @(negedge clk); c0 = count_o;
        repeat (10) @(negedge clk);
        check("R3 hold", count_o, c0);
        sync();

        // R5 frame start ignored while disabled
        @(negedge clk); s0 = stamp_o;
        sync();
        frame_start_i = 1;
        sync();
        frame_start_i = 0;
        @(negedge clk);
        check("R5 stamp", stamp_o, s0);
        sync();
        wr(2'd0, 32'd1);
        repeat (5) sync();

        // R10 divider 0
        wr(2'd1, 32'd0);
        repeat (2) sync();
        @(negedge clk); c0 = count_o;
        @(negedge clk);
        check("R10 step", count_o, c0 + 1);
        sync();

        // R4 capture
        frame_start_i = 1;
        @(negedge clk); c0 = count_o;
        sync();
        frame_start_i = 0;
        @(negedge clk);
        check("R4 capture", stamp_o, c0);
        sync();

        // R9 stamp write ignored, control readback
        wr(2'd3, 32'h1234_5678);
        @(negedge clk);
        check("R9 stamp ro", stamp_o, c0);
        sync();
        cfg_addr = 2'd0;
        @(negedge clk);
        check("R9 ctrl read", cfg_rdata, 32'd1);
        sync();

        // R8 preload wins over advance; R6 single wrap with irq masked (R7)
        wr(2'd2, 32'hFFFF_FFF0);
        @(negedge clk);
        check("R8 load", count_o, 32'hFFFF_FFF0);
        hits = 0;
        for (int i = 0; i < 30; i++) begin
            if (wrap_pulse_o) begin
                hits++;
                check("R6 zero", count_o, 32'd0);
            end
            check("R7 masked", {31'd0, wrap_irq_o}, 32'd0);
            @(negedge clk);
        end
        check("R6 once", hits, 32'd1);
        sync();

        // R7 irq enabled
        wr(2'd0, 32'd3);
        wr(2'd2, 32'hFFFF_FFFE);
        hits = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (wrap_irq_o) hits++;
        end
        check("R7 irq once", hits, 32'd1);
        sync();

        // R11 divider lowered below reached phase
        wr(2'd1, 32'd10);
        @(negedge clk); c0 = count_o;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (count_o != c0) break;
        end
        c0 = count_o;
        repeat (5) @(posedge clk);
        #1;
        cfg_we = 1; cfg_addr = 2'd1; cfg_wdata = 32'd2;
        sync();
        cfg_we = 0;
        @(negedge clk);
        check("R11 before", count_o, c0);
        @(negedge clk);
        check("R11 after", count_o, c0 + 1);

        repeat (3) sync();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule